// File: doc/BRIEF.md
# Flash Program/Erase Sequencer with Suspend

This block is the control sequencer for a flash array divided into 64 equal blocks. It takes commands that have already been decoded from the bus (read, block erase, word program, suspend, resume, lock one block, unlock every block, clear status). It runs at most one array algorithm at a time. A cycle counter stands in for the algorithm's duration. The block reports progress through an 8-bit status value and a separate ready output.

An erase in progress can be suspended. While it is suspended, reads and programs may target any block except the one being erased. A program in progress can also be suspended, but then only reads outside the programmed block are permitted. Resume continues the paused algorithm from where its counter stopped.

Each block has a lock bit, and all lock bits are set at power-up. A program or erase is refused when the target block's lock bit is set, unless the lock-override input is high. Every program and erase is refused while the program/erase enable input is low. Any refused request raises a sticky error flag. The ordinary reset returns the sequencer to idle and leaves the lock bits unchanged.

Top module: `flash_pe_seq`

## Requirements
- R1: A synchronous reset (rst_n low) gives status 0x80, ready 1 and rd_en 0, and leaves the lock bits as they were. A synchronous power-on reset (por_n low) sets all 64 lock bits.
- R2: The block index is cmd_addr[21:16]. When wide_mode is 1, an accepted read forwards rd_addr with bit 0 forced to 0. When wide_mode is 0, cmd_addr is forwarded unchanged.
- R3: From idle, an accepted erase (op 1) holds ready low for exactly ERASE_CYC clock edges after the accepting edge. An accepted program (op 2) holds ready low for exactly PROG_CYC edges.
- R4: While pe_en is 0, every erase (op 1) and program (op 2) is refused: ready stays 1 and the error bit, status bit 5, is set.
- R5: An erase or program that targets a locked block is refused with the error bit set, unless prot_ovr is 1, in which case it is accepted.
- R6: Lock (op 5) sets the lock bit of the addressed block, and unlock-all (op 6) clears all 64 lock bits. Both are accepted only in idle; anywhere else they are refused with the error bit set and have no effect.
- R7: Suspend (op 3) during an erase gives status bit 6 = 1 and ready 1. Suspend during a program gives status bit 2 = 1 and ready 1. The counter does not advance on the suspending edge. Resume (op 4) continues the paused counter, so a suspended erase is busy for ERASE_CYC+1 edges in total. Suspend and resume are ignored in other states, and completion takes priority over a suspend on the same edge.
- R8: Under erase suspend, reads and programs of any other block are accepted, and both are refused for the suspended block. A program accepted under erase suspend runs for PROG_CYC edges with ready 0 and status bit 6 still 1, then returns to erase suspend.
- R9: Under program suspend, reads of other blocks are accepted. Reads of the suspended block are refused, and so are all programs and erases.
- R10: A read (op 0) is accepted in idle, or in a suspend state when R8 or R9 allow it. An accepted read gives rd_en = 1 on the following cycle with the forwarded address. A read made while ready is 0 is refused with the error bit set.
- R11: The error bit stays set until a clear-status command (op 7).
- R12: The ready output always equals status bit 7. Status bits 4, 3, 1 and 0 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset of sequencer state |
| por_n | input | 1 | Synchronous active-low power-on reset; sets all lock bits |
| prot_ovr | input | 1 | Lock override: lock bits are ignored while it is high |
| pe_en | input | 1 | Program/erase enable; 0 refuses all programs and erases |
| cmd_valid | input | 1 | Command strobe, one command per cycle |
| cmd_op | input | 3 | Command code (0 read, 1 erase, 2 program, 3 suspend, 4 resume, 5 lock, 6 unlock all, 7 clear status) |
| cmd_addr | input | ADDR_W | Word address; top BLK_W bits select the block |
| wide_mode | input | 1 | 32-bit organisation: address bit 0 is ignored |
| ready | output | 1 | 1 when no algorithm is running |
| status | output | 8 | Status: bit 7 ready, bit 6 erase suspended, bit 5 error, bit 2 program suspended |
| rd_en | output | 1 | One-cycle strobe forwarding an accepted read to the array |
| rd_addr | output | ADDR_W | Address of the forwarded read |

## Verification
A wrong internal state shows up at the ports in one of two ways. A state or suspend-tag error appears in the status bits or in rd_en on the cycle after the command it affects. A counter error shows as ready returning high too early or too late, so it becomes visible only at the end of the algorithm, up to ERASE_CYC cycles later. A corrupted lock bit stays hidden until a program or erase targets that block. For this reason the bench retargets locked blocks after every event that should or should not change them, and it compares every output against a behavioural model on every clock.

// File: rtl/flash_seq_pkg.sv
// Shared command codes, sequencer states and status bit positions.
package flash_seq_pkg;

    typedef enum logic [2:0] {
        OP_READ       = 3'd0,
        OP_ERASE      = 3'd1,
        OP_PROG       = 3'd2,
        OP_SUSPEND    = 3'd3,
        OP_RESUME     = 3'd4,
        OP_LOCK       = 3'd5,
        OP_UNLOCK_ALL = 3'd6,
        OP_CLR_STAT   = 3'd7
    } seq_op_e;

    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_ERASE   = 3'd1,
        ST_PROG    = 3'd2,
        ST_ESUSP   = 3'd3,
        ST_PSUSP   = 3'd4,
        ST_ESPROG  = 3'd5
    } seq_state_e;

    localparam int STAT_READY = 7;
    localparam int STAT_ESUSP = 6;
    localparam int STAT_ERR   = 5;
    localparam int STAT_PSUSP = 2;

endpackage

// File: rtl/flash_lock_bank.sv
// Per-block lock bits.
// Assumes: por_n has priority; set and clear are never requested together.
module flash_lock_bank #(
    parameter int BLK_W  = 6,
    localparam int BLOCKS = 1 << BLK_W
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              set_en,
    input  logic [BLK_W-1:0]  set_blk,
    input  logic              clr_all,
    output logic [BLOCKS-1:0] lock_q
);

    for (genvar i = 0; i < BLOCKS; i++) begin : g_bit
        // One lock flop: power-on sets it, unlock-all clears it, lock sets it.
        always_ff @(posedge clk) begin
            if (!por_n) begin
                lock_q[i] <= 1'b1;
            end else if (clr_all) begin
                lock_q[i] <= 1'b0;
            end else if (set_en && (set_blk == BLK_W'(i))) begin
                lock_q[i] <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/flash_op_timer.sv
// Down-counter standing in for an array algorithm.
// load arms it with CYCLES-1, and run advances it while it is non-zero.
// done is high while the count is zero.
module flash_op_timer #(
    parameter int CYCLES = 24,
    localparam int CNT_W = (CYCLES > 1) ? $clog2(CYCLES) : 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic run,
    output logic done
);

    localparam logic [CNT_W-1:0] LAST = CNT_W'(CYCLES - 1);

    logic [CNT_W-1:0] cnt_q;

    // Load, decrement or hold the remaining count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= LAST;
        end else if (run && (cnt_q != '0)) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign done = (cnt_q == '0);

endmodule

// File: rtl/flash_seq_ctrl.sv
// Sequencer state machine. It decides whether each command is accepted
// under the current state, its permission rules and the lock state.
// Assumes: prot_hit is already resolved against the override input;
// e_done and p_done come from timers that this module loads and runs.
module flash_seq_ctrl
    import flash_seq_pkg::*;
#(
    parameter int BLK_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_valid,
    input  seq_op_e          cmd_op,
    input  logic [BLK_W-1:0] cmd_blk,
    input  logic             pe_en,
    input  logic             prot_hit,
    input  logic             e_done,
    input  logic             p_done,
    output logic             e_load,
    output logic             e_run,
    output logic             p_load,
    output logic             p_run,
    output logic             lock_set,
    output logic             unlock_all,
    output logic             rd_accept,
    output seq_state_e       state_o,
    output logic             err_o
);

    seq_state_e       state_q, state_d;
    logic             err_q;
    logic [BLK_W-1:0] eblk_q, pblk_q;
    logic             refuse, clr_err, write_ok, sus_cmd, res_cmd;

    assign write_ok = pe_en && !prot_hit;
    assign sus_cmd  = cmd_valid && (cmd_op == OP_SUSPEND);
    assign res_cmd  = cmd_valid && (cmd_op == OP_RESUME);

    // Command admission under the current state.
    always_comb begin
        e_load     = 1'b0;
        p_load     = 1'b0;
        lock_set   = 1'b0;
        unlock_all = 1'b0;
        rd_accept  = 1'b0;
        refuse     = 1'b0;
        clr_err    = 1'b0;
        if (cmd_valid) begin
            unique case (cmd_op)
                OP_READ: begin
                    if ((state_q == ST_IDLE) ||
                        ((state_q == ST_ESUSP) && (cmd_blk != eblk_q)) ||
                        ((state_q == ST_PSUSP) && (cmd_blk != pblk_q)))
                        rd_accept = 1'b1;
                    else
                        refuse = 1'b1;
                end
                OP_ERASE: begin
                    if ((state_q == ST_IDLE) && write_ok) e_load = 1'b1;
                    else refuse = 1'b1;
                end
                OP_PROG: begin
                    if (write_ok && ((state_q == ST_IDLE) ||
                        ((state_q == ST_ESUSP) && (cmd_blk != eblk_q))))
                        p_load = 1'b1;
                    else
                        refuse = 1'b1;
                end
                OP_LOCK: begin
                    if (state_q == ST_IDLE) lock_set = 1'b1;
                    else refuse = 1'b1;
                end
                OP_UNLOCK_ALL: begin
                    if (state_q == ST_IDLE) unlock_all = 1'b1;
                    else refuse = 1'b1;
                end
                OP_CLR_STAT: clr_err = 1'b1;
                OP_SUSPEND, OP_RESUME: ;
            endcase
        end
    end

    // Next state; completion wins over a suspend on the same edge.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (e_load)      state_d = ST_ERASE;
                else if (p_load) state_d = ST_PROG;
            end
            ST_ERASE: begin
                if (e_done)       state_d = ST_IDLE;
                else if (sus_cmd) state_d = ST_ESUSP;
            end
            ST_PROG: begin
                if (p_done)       state_d = ST_IDLE;
                else if (sus_cmd) state_d = ST_PSUSP;
            end
            ST_ESUSP: begin
                if (res_cmd)     state_d = ST_ERASE;
                else if (p_load) state_d = ST_ESPROG;
            end
            ST_PSUSP: begin
                if (res_cmd) state_d = ST_PROG;
            end
            ST_ESPROG: begin
                if (p_done) state_d = ST_ESUSP;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Timers advance only while their algorithm owns the array.
    assign e_run = (state_q == ST_ERASE) && !sus_cmd;
    assign p_run = ((state_q == ST_PROG) && !sus_cmd) || (state_q == ST_ESPROG);

    // State, sticky error and target-block registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            err_q   <= 1'b0;
            eblk_q  <= '0;
            pblk_q  <= '0;
        end else begin
            state_q <= state_d;
            if (refuse)       err_q <= 1'b1;
            else if (clr_err) err_q <= 1'b0;
            if (e_load) eblk_q <= cmd_blk;
            if (p_load) pblk_q <= cmd_blk;
        end
    end

    assign state_o = state_q;
    assign err_o   = err_q;

endmodule

// File: rtl/flash_pe_seq.sv
// Top of the program/erase sequencer. It joins the lock bank, two
// algorithm timers and the state machine, and it forms status and the
// forwarded read.
// Assumes: commands are decoded and arrive one per cycle on cmd_*.
module flash_pe_seq
    import flash_seq_pkg::*;
#(
    parameter int ADDR_W    = 22,
    parameter int BLK_W     = 6,
    parameter int ERASE_CYC = 24,
    parameter int PROG_CYC  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              por_n,
    input  logic              prot_ovr,
    input  logic              pe_en,
    input  logic              cmd_valid,
    input  logic [2:0]        cmd_op,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic              wide_mode,
    output logic              ready,
    output logic [7:0]        status,
    output logic              rd_en,
    output logic [ADDR_W-1:0] rd_addr
);

    localparam int BLOCKS = 1 << BLK_W;

    logic [BLK_W-1:0]  blk;
    logic [BLOCKS-1:0] lock_q;
    logic              prot_hit, e_done, p_done, e_load, e_run, p_load, p_run;
    logic              lock_set, unlock_all, rd_accept, err;
    seq_state_e        state;

    assign blk      = cmd_addr[ADDR_W-1 -: BLK_W];
    assign prot_hit = lock_q[blk] && !prot_ovr;

    flash_lock_bank #(.BLK_W(BLK_W)) u_locks (
        .clk     (clk),
        .por_n   (por_n),
        .set_en  (lock_set && rst_n),
        .set_blk (blk),
        .clr_all (unlock_all && rst_n),
        .lock_q  (lock_q)
    );

    flash_op_timer #(.CYCLES(ERASE_CYC)) u_etmr (
        .clk (clk), .rst_n (rst_n), .load (e_load), .run (e_run), .done (e_done)
    );

    flash_op_timer #(.CYCLES(PROG_CYC)) u_ptmr (
        .clk (clk), .rst_n (rst_n), .load (p_load), .run (p_run), .done (p_done)
    );

    flash_seq_ctrl #(.BLK_W(BLK_W)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd_valid  (cmd_valid),
        .cmd_op     (seq_op_e'(cmd_op)),
        .cmd_blk    (blk),
        .pe_en      (pe_en),
        .prot_hit   (prot_hit),
        .e_done     (e_done),
        .p_done     (p_done),
        .e_load     (e_load),
        .e_run      (e_run),
        .p_load     (p_load),
        .p_run      (p_run),
        .lock_set   (lock_set),
        .unlock_all (unlock_all),
        .rd_accept  (rd_accept),
        .state_o    (state),
        .err_o      (err)
    );

    // Status assembly from the sequencer state and error flag.
    always_comb begin
        status             = 8'h00;
        status[STAT_READY] = (state == ST_IDLE) || (state == ST_ESUSP) || (state == ST_PSUSP);
        status[STAT_ESUSP] = (state == ST_ESUSP) || (state == ST_ESPROG);
        status[STAT_ERR]   = err;
        status[STAT_PSUSP] = (state == ST_PSUSP);
    end

    assign ready = status[STAT_READY];

    // Register the forwarded read strobe and its address.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_en   <= 1'b0;
            rd_addr <= '0;
        end else begin
            rd_en <= rd_accept;
            if (rd_accept)
                rd_addr <= wide_mode ? {cmd_addr[ADDR_W-1:1], 1'b0} : cmd_addr;
        end
    end

endmodule

// File: rtl/flash_pe_seq_chk.sv
// Port-level temporal checks for the sequencer, bound to the top module.
module flash_pe_seq_chk #(
    parameter int ADDR_W = 22
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cmd_valid,
    input logic [2:0]        cmd_op,
    input logic              pe_en,
    input logic              wide_mode,
    input logic              ready,
    input logic [7:0]        status,
    input logic              rd_en,
    input logic [ADDR_W-1:0] rd_addr
);

    logic idle_now;
    assign idle_now = status[7] && !status[6] && !status[2];

    // R4: a program or erase with the enable low never starts.
    assert_disabled_refused_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (idle_now && cmd_valid && (cmd_op == 3'd1 || cmd_op == 3'd2) && !pe_en)
        |=> (status[7] && status[5]))
        else $error("R4: write started with enable low");

    // R9: a program under program suspend is refused.
    assert_psusp_no_prog_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (status[2] && cmd_valid && cmd_op == 3'd2) |=> (status[2] && status[5]))
        else $error("R9: program accepted under program suspend");

    // R10: a read issued while busy is never forwarded.
    assert_busy_read_refused_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!status[7] && cmd_valid && cmd_op == 3'd0) |=> (!rd_en && status[5]))
        else $error("R10: read forwarded while busy");

    // R10: every forwarded read follows a read command.
    assert_read_has_cmd_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |-> $past(cmd_valid && cmd_op == 3'd0))
        else $error("R10: spurious read strobe");

    // R11: the error flag holds until clear-status.
    assert_err_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (status[5] && !(cmd_valid && cmd_op == 3'd7)) |=> status[5])
        else $error("R11: error flag dropped");

    // R7: the two suspend indications never coexist.
    assert_susp_exclusive_R7: assert property (@(posedge clk) disable iff (!rst_n)
        status[6] |-> !status[2])
        else $error("R7: both suspend bits set");

    // R2: wide reads forward an even address.
    assert_wide_even_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && $past(wide_mode)) |-> !rd_addr[0])
        else $error("R2: odd address in wide mode");

    // R3: busy begins only on an erase, program or resume command.
    assert_busy_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ready) |-> $past(cmd_valid && (cmd_op == 3'd1 || cmd_op == 3'd2 || cmd_op == 3'd4)))
        else $error("R3: busy without a cause");

endmodule

bind flash_pe_seq flash_pe_seq_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/flash_pe_seq_bench.sv
module flash_pe_seq_bench;

    localparam int E  = 24;
    localparam int P  = 6;
    localparam int AW = 22;

    logic          clk = 1'b0;
    logic          rst_n, por_n, prot_ovr, pe_en, cmd_valid, wide_mode;
    logic [2:0]    cmd_op;
    logic [AW-1:0] cmd_addr;
    logic          ready, rd_en;
    logic [7:0]    status;
    logic [AW-1:0] rd_addr;

    always #2 clk = ~clk;

    flash_pe_seq #(.ADDR_W(AW), .BLK_W(6), .ERASE_CYC(E), .PROG_CYC(P)) u_flash_pe_seq (
        .clk(clk), .rst_n(rst_n), .por_n(por_n), .prot_ovr(prot_ovr), .pe_en(pe_en),
        .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_addr(cmd_addr), .wide_mode(wide_mode),
        .ready(ready), .status(status), .rd_en(rd_en), .rd_addr(rd_addr)
    );

    int    n_chk = 0;
    int    n_bad = 0;
    bit    cmp_on = 0;
    bit    fin = 0;
    string cur_req = "R1";
    int    busy_seen = 0;

    // Behavioural reference model: 0 idle, 1 erasing, 2 programming,
    // 3 erase suspended, 4 program suspended, 5 program inside erase suspend.
    int            m_mode = 0, m_erem = 0, m_prem = 0, m_eblk = 0, m_pblk = 0;
    bit            m_err = 0, m_rd = 0;
    bit [63:0]     m_lock = '0;
    logic [AW-1:0] m_rdaddr = '0;

    function automatic logic [7:0] exp_status();
        logic [7:0] s = 8'h00;
        s[7] = (m_mode == 0) || (m_mode == 3) || (m_mode == 4);
        s[6] = (m_mode == 3) || (m_mode == 5);
        s[5] = m_err;
        s[2] = (m_mode == 4);
        return s;
    endfunction

    always @(posedge clk) begin
        int blk, nm;
        bit wok, sus, res, eld, pld, lk, ulk, rdn, errn;
        if (!ready) busy_seen++;
        if (!rst_n) begin
            m_mode = 0; m_err = 0; m_rd = 0; m_erem = 0; m_prem = 0;
            m_eblk = 0; m_pblk = 0;
            if (!por_n) m_lock = '1;
        end else begin
            blk = int'(cmd_addr[AW-1:AW-6]);
            wok = pe_en && (!m_lock[blk] || prot_ovr);
            sus = cmd_valid && cmd_op == 3'd3;
            res = cmd_valid && cmd_op == 3'd4;
            eld = 0; pld = 0; lk = 0; ulk = 0; rdn = 0; errn = m_err;
            if (cmd_valid) begin
                case (cmd_op)
                    3'd0: if (m_mode == 0 || (m_mode == 3 && blk != m_eblk) ||
                              (m_mode == 4 && blk != m_pblk)) rdn = 1; else errn = 1;
                    3'd1: if (m_mode == 0 && wok) eld = 1; else errn = 1;
                    3'd2: if (wok && (m_mode == 0 || (m_mode == 3 && blk != m_eblk))) pld = 1;
                          else errn = 1;
                    3'd5: if (m_mode == 0) lk = 1; else errn = 1;
                    3'd6: if (m_mode == 0) ulk = 1; else errn = 1;
                    3'd7: errn = 0;
                    default: ;
                endcase
            end
            nm = m_mode;
            case (m_mode)
                0: if (eld) begin nm = 1; m_erem = E - 1; m_eblk = blk; end
                   else if (pld) begin nm = 2; m_prem = P - 1; m_pblk = blk; end
                1: if (m_erem == 0) nm = 0; else if (sus) nm = 3; else m_erem--;
                2: if (m_prem == 0) nm = 0; else if (sus) nm = 4; else m_prem--;
                3: if (res) nm = 1;
                   else if (pld) begin nm = 5; m_prem = P - 1; m_pblk = blk; end
                4: if (res) nm = 2;
                5: if (m_prem == 0) nm = 3; else m_prem--;
                default: nm = 0;
            endcase
            m_mode = nm;
            m_err  = errn;
            m_rd   = rdn;
            if (rdn) m_rdaddr = wide_mode ? {cmd_addr[AW-1:1], 1'b0} : cmd_addr;
            if (!por_n) m_lock = '1;
            else if (ulk) m_lock = '0;
            else if (lk) m_lock[blk] = 1'b1;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp,
                       input string what);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Per-clock comparison against the model.
    always @(negedge clk) begin
        if (cmp_on && !fin) begin
            chk(cur_req, {24'h0, status}, {24'h0, exp_status()}, "model status");
            chk("R12", {31'h0, ready}, {31'h0, status[7]}, "ready vs status bit 7");
            chk("R12", {28'h0, status[4:3], status[1:0]}, 32'h0, "reserved status bits");
            chk(cur_req, {31'h0, rd_en}, {31'h0, m_rd}, "model rd_en");
            if (m_rd) chk(cur_req, {10'h0, rd_addr}, {10'h0, m_rdaddr}, "model rd_addr");
        end
    end

    task automatic issue(input logic [2:0] op, input int blk, input logic [15:0] low);
        cmd_valid = 1'b1;
        cmd_op    = op;
        cmd_addr  = {blk[5:0], low};
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic wait_ready();
        for (int i = 0; i < 1000 && ready !== 1'b1; i++) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!fin) begin
            fin = 1;
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog run did not finish actual=hung expected=done");
        finish_run();
    end

    initial begin
        int b0;
        rst_n = 0; por_n = 0; prot_ovr = 0; pe_en = 1; cmd_valid = 0;
        wide_mode = 0; cmd_op = 3'd0; cmd_addr = '0;
        repeat (3) @(negedge clk);
        rst_n = 1; por_n = 1;
        cmp_on = 1;

        // R1: reset state
        chk("R1", {24'h0, status}, 32'h80, "status after reset");
        chk("R1", {31'h0, rd_en}, 32'h0, "rd_en after reset");

        // R5: power-up locks refuse an erase
        cur_req = "R5";
        issue(3'd1, 3, 16'h0);
        chk("R5", {24'h0, status}, 32'hA0, "erase of locked block");
        // R11: error survives an ignored command, then clears
        cur_req = "R11";
        issue(3'd3, 0, 16'h0);
        chk("R11", {24'h0, status}, 32'hA0, "error held");
        issue(3'd7, 0, 16'h0);
        chk("R11", {24'h0, status}, 32'h80, "error cleared");

        // R5: override admits the locked block; R3 erase length
        cur_req = "R5";
        prot_ovr = 1;
        b0 = busy_seen;
        issue(3'd1, 3, 16'h0);
        prot_ovr = 0;
        chk("R5", {31'h0, ready}, 32'h0, "erase with override starts");
        wait_ready();
        chk("R3", busy_seen - b0, E, "erase busy edges");

        // R6 unlock all, R4 enable low
        cur_req = "R6";
        issue(3'd6, 0, 16'h0);
        cur_req = "R4";
        pe_en = 0;
        issue(3'd1, 5, 16'h0);
        chk("R4", {24'h0, status}, 32'hA0, "erase with enable low");
        issue(3'd2, 5, 16'h0);
        chk("R4", {24'h0, status}, 32'hA0, "program with enable low");
        pe_en = 1;
        issue(3'd7, 0, 16'h0);

        // R3: erase and program lengths on unlocked blocks
        cur_req = "R3";
        b0 = busy_seen;
        issue(3'd1, 5, 16'h0);
        wait_ready();
        chk("R3", busy_seen - b0, E, "erase busy edges");
        b0 = busy_seen;
        issue(3'd2, 9, 16'h0040);
        chk("R3", {24'h0, status}, 32'h00, "program busy status");
        wait_ready();
        chk("R3", busy_seen - b0, P, "program busy edges");

        // R10: read while busy refused
        cur_req = "R10";
        issue(3'd1, 1, 16'h0);
        issue(3'd0, 2, 16'h0);
        chk("R10", {31'h0, rd_en}, 32'h0, "read while busy");
        chk("R10", {24'h0, status}, 32'h20, "read while busy error");
        wait_ready();
        issue(3'd7, 0, 16'h0);

        // R2 / R10: forwarded reads in both organisations
        cur_req = "R2";
        issue(3'd0, 18, 16'h2345);
        chk("R10", {31'h0, rd_en}, 32'h1, "idle read strobe");
        chk("R2", {10'h0, rd_addr}, {10'h0, 6'd18, 16'h2345}, "narrow read address");
        wide_mode = 1;
        issue(3'd0, 0, 16'hABCD);
        wide_mode = 0;
        chk("R2", {10'h0, rd_addr}, {10'h0, 6'd0, 16'hABCC}, "wide read address");

        // R7 / R8: erase suspend with a nested program
        cur_req = "R7";
        b0 = busy_seen;
        issue(3'd1, 10, 16'h0);
        repeat (5) @(negedge clk);
        issue(3'd3, 0, 16'h0);
        chk("R7", {24'h0, status}, 32'hC0, "erase suspended");
        cur_req = "R8";
        issue(3'd0, 10, 16'h0010);
        chk("R8", {31'h0, rd_en}, 32'h0, "read of suspended block");
        chk("R8", {24'h0, status}, 32'hE0, "read of suspended block error");
        issue(3'd7, 0, 16'h0);
        issue(3'd0, 11, 16'h0011);
        chk("R8", {31'h0, rd_en}, 32'h1, "read of other block");
        issue(3'd2, 10, 16'h0);
        chk("R8", {24'h0, status}, 32'hE0, "program of suspended block");
        issue(3'd7, 0, 16'h0);
        issue(3'd2, 12, 16'h0);
        chk("R8", {24'h0, status}, 32'h40, "nested program busy");
        wait_ready();
        chk("R8", {24'h0, status}, 32'hC0, "back to erase suspend");
        cur_req = "R7";
        issue(3'd4, 0, 16'h0);
        chk("R7", {24'h0, status}, 32'h00, "erase resumed");
        wait_ready();
        chk("R7", busy_seen - b0, E + 1 + P, "suspended erase plus nested program edges");

        // R9: program suspend permissions
        cur_req = "R9";
        issue(3'd2, 20, 16'h0);
        issue(3'd3, 0, 16'h0);
        chk("R9", {24'h0, status}, 32'h84, "program suspended");
        issue(3'd0, 21, 16'h0);
        chk("R9", {31'h0, rd_en}, 32'h1, "read of other block");
        issue(3'd0, 20, 16'h0);
        chk("R9", {24'h0, status}, 32'hA4, "read of suspended block");
        issue(3'd7, 0, 16'h0);
        issue(3'd2, 21, 16'h0);
        chk("R9", {24'h0, status}, 32'hA4, "program under program suspend");
        issue(3'd7, 0, 16'h0);
        issue(3'd1, 21, 16'h0);
        chk("R9", {24'h0, status}, 32'hA4, "erase under program suspend");
        issue(3'd7, 0, 16'h0);
        issue(3'd4, 0, 16'h0);
        wait_ready();
        chk("R9", {24'h0, status}, 32'h80, "program completed after resume");

        // R6: lock a block; R1: ordinary reset keeps the lock
        cur_req = "R6";
        issue(3'd5, 30, 16'h0);
        issue(3'd2, 30, 16'h0);
        chk("R6", {24'h0, status}, 32'hA0, "program of newly locked block");
        cur_req = "R1";
        rst_n = 0;
        @(negedge clk);
        rst_n = 1;
        chk("R1", {24'h0, status}, 32'h80, "status after mid-run reset");
        issue(3'd1, 30, 16'h0);
        chk("R1", {24'h0, status}, 32'hA0, "lock kept across reset");
        issue(3'd7, 0, 16'h0);

        // R6: lock while busy is refused and has no effect
        cur_req = "R6";
        issue(3'd2, 31, 16'h0);
        issue(3'd5, 31, 16'h0);
        chk("R6", {24'h0, status}, 32'h20, "lock while busy refused");
        wait_ready();
        issue(3'd7, 0, 16'h0);
        issue(3'd1, 31, 16'h0);
        chk("R6", {24'h0, status}, 32'h00, "block left unlocked");
        wait_ready();
        repeat (2) @(negedge clk);

        finish_run();
    end

endmodule